// File: doc/BRIEF.md
# Flash Block Program/Erase Lock Register

This block is a 32-bit control register that keeps one lock bit per flash block. Each bit decides whether the block may receive program and erase pulses: 1 blocks them and 0 allows them. The lock bits form three groups: one bit for the shadow (configuration) block, a group for the mid address space and a group for the low address space. The whole lock vector goes to the flash controller as a combinational output.

Software cannot touch the lock bits until it has opened the register. It opens the register by writing one fixed 32-bit password, which sets a sticky enable flag. Only a reset clears that flag. Lock writes are also refused while a program/erase operation is running, while a high-voltage operation is suspended, and while the test-mode input is high.

On reset every lock bit takes its value from a shadow-configuration input. An erased shadow reads as all ones, so blocks come up locked. A parameter mask marks which mid-space and low-space blocks exist. The bit of a block that does not exist is fixed at 1.

Top module: `flash_lock_reg`

## Requirements
- R1: A write of exactly 0xA1A11111 sets the enable flag one cycle later. The flag then stays 1 until the next reset, whatever is written afterwards.
- R2: The enable flag reads back on rdData[31]. It is 0 after reset, and no write can clear it.
- R3: rdData places the shadow lock on bit 20, the mid locks on bits 17:16 (mid block 1 on bit 17) and the low locks on bits 9:0 (low block k on bit k). Every other bit reads 0, and a read changes nothing. lockVec is ordered {shadow, mid[1:0], low[9:0]}.
- R4: While the enable flag is 0, every written value other than the password leaves all lock bits unchanged.
- R5: A password write never changes a lock bit, including when the flag is already 1.
- R6: When the flag is 1 and nothing blocks writes, a non-password write loads each present lock bit from its field position in wrData. The new value is visible in the next cycle.
- R7: A pulse on opStart blocks lock writes from that cycle through the cycle in which opDone is high. Writes are accepted again from the following cycle.
- R8: Lock writes are ignored in any cycle in which hvSuspend or testMode is high.
- R9: While rstN is low, each present lock bit loads the matching bit of shadowCfg, and the enable flag and the busy state clear.
- R10: A lock bit whose block is absent from MID_PRESENT/LOW_PRESENT reads 1 after every reset and under every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents, reserved bits zero |
| shadowCfg | input | 13 | Reset lock values {shadow, mid[1:0], low[9:0]} |
| opStart | input | 1 | Interlock write started a program/erase operation |
| opDone | input | 1 | Program/erase operation complete |
| hvSuspend | input | 1 | High-voltage operation suspended |
| testMode | input | 1 | Test-mode enable |
| lockVec | output | 13 | Lock vector to the flash controller {shadow, mid, low} |

## Verification
The assertions check four things on every cycle: the enable flag never falls, no lock write strobe appears while the flag is 0, while the register is busy, suspended or in test mode, or on a password value, and the lock bits hold whenever no write strobe is present. The bench's scenarios cover the rest. They show the reset load from shadowCfg, the exact field positions on the read bus, the absent blocks that stay locked, and the accepted writes. A sweep over all 8192 lock patterns, with reserved bits set and the enable bit toggled, confirms the field mapping. The busy window from opStart to opDone is checked cycle by cycle.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  typedef struct packed {
    logic setEnable;
    logic lockWrite;
  } lockStrobes_t;
endpackage

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] PASSWORD = 32'hA1A1_1111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              opStart,
  input  logic              opDone,
  input  logic              hvSuspend,
  input  logic              testMode,
  output logic              enable,
  output lockStrobes_t      strobes
);
  logic busy;
  logic isPassword;
  logic blocked;

  assign isPassword = (wrData == DATA_W'(PASSWORD));
  assign blocked    = busy | opStart | hvSuspend | testMode;

  always_comb begin
    strobes.setEnable = wrEn & isPassword & ~enable;
    strobes.lockWrite = wrEn & ~isPassword & enable & ~blocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  enable <= 1'b0;
    else if (strobes.setEnable) enable <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busy <= 1'b0;
    else if (opStart) busy <= 1'b1;
    else if (opDone)  busy <= 1'b0;
  end

  // R1
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> enable);
  // R4
  no_enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strobes.lockWrite);
  // R5
  password_no_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == DATA_W'(PASSWORD)) |-> !strobes.lockWrite);
  // R7 R8
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (busy || hvSuspend || testMode)) |-> !strobes.lockWrite);
endmodule

// File: rtl/flash_lock_dp.sv
module flash_lock_dp
  import flash_lock_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               MID_W       = 2,
  parameter int               LOW_W       = 10,
  parameter logic [MID_W-1:0] MID_PRESENT = '1,
  parameter logic [LOW_W-1:0] LOW_PRESENT = '1,
  parameter int               EN_POS      = 31,
  parameter int               SHADOW_POS  = 20,
  parameter int               MID_LSB     = 16,
  parameter int               LOW_LSB     = 0,
  localparam int              LOCK_W      = 1 + MID_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobes_t      strobes,
  input  logic              enable,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LOCK_W-1:0] shadowCfg,
  output logic [LOCK_W-1:0] lockVec,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [LOCK_W-1:0] PRESENT = {1'b1, MID_PRESENT, LOW_PRESENT};

  logic [LOCK_W-1:0] wrVec;
  logic [LOCK_W-1:0] lockQ;

  assign wrVec = {wrData[SHADOW_POS], wrData[MID_LSB +: MID_W], wrData[LOW_LSB +: LOW_W]};

  for (genvar i = 0; i < LOCK_W; i++) begin : g_lock
    if (PRESENT[i]) begin : g_impl
      logic bitQ;
      always_ff @(posedge clk) begin
        if (!rstN)                  bitQ <= shadowCfg[i];
        else if (strobes.lockWrite) bitQ <= wrVec[i];
      end
      assign lockQ[i] = bitQ;
    end else begin : g_absent
      assign lockQ[i] = 1'b1;
    end
  end

  assign lockVec = lockQ;

  always_comb begin
    rdData = '0;
    rdData[EN_POS]              = enable;
    rdData[SHADOW_POS]          = lockQ[LOCK_W-1];
    rdData[MID_LSB +: MID_W]    = lockQ[LOW_W +: MID_W];
    rdData[LOW_LSB +: LOW_W]    = lockQ[LOW_W-1:0];
  end

  // R4 R7 R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lockWrite |=> $stable(lockQ));
  // R6 R10
  lock_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lockWrite |=> (lockQ == ($past(wrVec) | ~PRESENT)));
endmodule

// File: rtl/flash_lock_reg.sv
module flash_lock_reg
  import flash_lock_pkg::*;
#(
  parameter int               MID_W       = 2,
  parameter int               LOW_W       = 10,
  parameter logic [MID_W-1:0] MID_PRESENT = '1,
  parameter logic [LOW_W-1:0] LOW_PRESENT = '1,
  parameter logic [31:0]      PASSWORD    = 32'hA1A1_1111,
  localparam int              LOCK_W      = 1 + MID_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [LOCK_W-1:0] shadowCfg,
  input  logic              opStart,
  input  logic              opDone,
  input  logic              hvSuspend,
  input  logic              testMode,
  output logic [LOCK_W-1:0] lockVec
);
  lockStrobes_t strobes;
  logic         enable;

  flash_lock_ctrl #(.DATA_W(32), .PASSWORD(PASSWORD)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .opStart(opStart), .opDone(opDone), .hvSuspend(hvSuspend),
    .testMode(testMode), .enable(enable), .strobes(strobes)
  );

  flash_lock_dp #(
    .DATA_W(32), .MID_W(MID_W), .LOW_W(LOW_W),
    .MID_PRESENT(MID_PRESENT), .LOW_PRESENT(LOW_PRESENT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enable(enable),
    .wrData(wrData), .shadowCfg(shadowCfg), .lockVec(lockVec), .rdData(rdData)
  );
endmodule

// File: tb/test_flash_lock_reg.sv
module test_flash_lock_reg;
  localparam logic [1:0]  MID_P = 2'b01;
  localparam logic [9:0]  LOW_P = 10'b11_1111_0111;
  localparam logic [12:0] PRES  = {1'b1, MID_P, LOW_P};
  localparam logic [31:0] PWD   = 32'hA1A1_1111;
  localparam logic [31:0] JUNK  = 32'h4A0C_0400;

  logic clk = 0, rstN = 0, wrEn = 0, opStart = 0, opDone = 0, hvSuspend = 0, testMode = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [12:0] shadowCfg = '1;
  logic [12:0] lockVec;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic        expEn;
  logic [12:0] expLock;

  always #4 clk = ~clk;

  flash_lock_reg #(.MID_PRESENT(MID_P), .LOW_PRESENT(LOW_P)) i_flash_lock_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .shadowCfg(shadowCfg), .opStart(opStart), .opDone(opDone),
    .hvSuspend(hvSuspend), .testMode(testMode), .lockVec(lockVec)
  );

  function automatic logic [31:0] wordOf(input logic [12:0] v);
    return {11'b0, v[12], 2'b0, v[11:10], 6'b0, v[9:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(tag, rdData, {expEn, 31'b0} | wordOf(expLock));
    chk({tag, " lockVec"}, {19'b0, lockVec}, {19'b0, expLock});
  endtask

  task automatic doReset(input logic [12:0] sh);
    @(negedge clk);
    rstN = 0; shadowCfg = sh;
    repeat (2) @(negedge clk);
    rstN = 1;
    expEn = 0; expLock = (sh & PRES) | ~PRES;
  endtask

  task automatic doWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  initial begin
    doReset(13'h1FFF);
    chkAll("R9 R2 reset all-ones shadow");
    doReset(13'h0000);
    chkAll("R10 R9 reset zero shadow absent stay locked");
    doReset(13'h0A5A);
    chkAll("R9 R3 reset mixed shadow");

    doWrite(32'h0000_0000);
    chkAll("R4 write while disabled");
    doWrite(32'h8000_0000);
    chkAll("R2 R4 enable bit not writable");

    doWrite(PWD);
    expEn = 1;
    chkAll("R1 R5 password sets enable only");
    chkAll("R3 second read no side effect");

    for (int p = 0; p < 8192; p++) begin
      logic [31:0] d;
      d = wordOf(13'(p)) | JUNK | ((p % 2 == 1) ? 32'h8000_0000 : 32'h0);
      doWrite(d);
      expLock = (13'(p) & PRES) | ~PRES;
      chkAll("R6 R3 R10 R2 sweep");
    end

    doWrite(PWD);
    chkAll("R5 password while enabled keeps locks");

    // R7: opStart window
    @(negedge clk); opStart = 1; wrEn = 1; wrData = wordOf(13'h0000);
    @(negedge clk); opStart = 0; wrEn = 0;
    chkAll("R7 write in opStart cycle");
    doWrite(wordOf(13'h0000));
    chkAll("R7 write while busy");
    @(negedge clk); opDone = 1; wrEn = 1; wrData = wordOf(13'h0000);
    @(negedge clk); opDone = 0; wrEn = 0;
    chkAll("R7 write in opDone cycle");
    doWrite(wordOf(13'h0000));
    expLock = ~PRES;
    chkAll("R7 write after opDone");

    // R8
    @(negedge clk); hvSuspend = 1;
    doWrite(wordOf(13'h1FFF));
    chkAll("R8 write during hvSuspend");
    @(negedge clk); hvSuspend = 0; testMode = 1;
    doWrite(wordOf(13'h1FFF));
    chkAll("R8 write during testMode");
    @(negedge clk); testMode = 0;
    doWrite(wordOf(13'h1555));
    expLock = (13'h1555 & PRES) | ~PRES;
    chkAll("R6 write after blocks lift");

    // R1: reset clears the flag, then writes need password again
    doReset(13'h0000);
    chkAll("R1 R9 reset clears enable");
    doWrite(wordOf(13'h1FFF));
    chkAll("R4 write disabled after reset");
    doWrite(PWD ^ 32'h1);
    chkAll("R1 near-password ignored");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule